// File: doc/BRIEF.md
# Synchronizable Half-Bridge PWM Generator

This block produces the two gate-drive waveforms of a hard-switched half-bridge from a free-running switching counter. A period value sets where the counter wraps. Four compare values set where output A rises and falls and where output B rises and falls. Software works out the dead times and writes the compare values through a simple write port. Those writes land in shadow copies. The copies move into the working set only when a new switching period begins, so a period is never built from a mix of old and new values.

Several converters that run in parallel can share one switching frequency. A unit set up as the timing leader drives a one-clock pulse on its sync pin each time its counter wraps. A unit set up as a follower watches the pin. When following is enabled, each rising edge on the pin restarts its counter at zero. The leader can also be told to send an extra pulse when a cycle-by-cycle current-limit fault starts. Because the outputs toggle only when the counter exactly equals a compare value, a restart that arrives before B's falling compare leaves B high into the next period. Writing zero as B's falling compare avoids this.

Top module: `hb_dpwm`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `pwm_a` = 0, `pwm_b` = 0, `cnt_out` = 0, `sync_out` = 0 and `sync_oe` = 0. After reset the sync pin is an input.
- R2: The counter steps up by one each clock from 0 to the active period value P. After P it returns to 0, so one period lasts P+1 clocks. After reset, P is the parameter `DEF_PRD`.
- R3: `pwm_a` goes high one clock after the counter equals event 1. It goes low one clock after the counter equals event 2. Writes use `cfg_wr_sel` 1 for event 1 and 2 for event 2.
- R4: `pwm_b` goes high one clock after the counter equals event 3. It goes low one clock after the counter equals event 4. Writes use `cfg_wr_sel` 3 and 4. With the half-bridge values event 3 = (P + event 1) >> 1 and event 2 = event 3 − dead time 1, A and B take these edges.
- R5: A write with `cfg_wr_sel` 0 stores a new period value. Like the event writes, it takes effect only when the counter next passes through 0 at the start of a period. The period already running keeps its old length.
- R6: `cfg_wr_sel` 5 writes the control bits: bit 0 = 1 makes the pin an input, bit 1 enables following, and bit 2 enables the current-limit pulse. When bit 0 and bit 1 are both set, a rising edge on `sync_in` makes `cnt_out` read 0 three clocks after the pin rises. Neither a falling edge nor a rising edge with bit 1 clear changes the count.
- R7: After a restart, a B pulse whose event-4 value has not been reached stays high until the counter next equals event 4. When event 4 is 0, B goes low one clock after the restart.
- R8: With control bit 0 = 0, `sync_oe` is 1, and `sync_out` is high for exactly the one clock in which the counter reads 0 after a wrap. With bit 0 = 1, `sync_oe` is 0 and `sync_out` stays 0.
- R9: In leader mode with bit 2 set, a rising edge on `cl_fault` makes `sync_out` high for one clock, on the cycle after the edge. The pulse at the wrap still occurs. With bit 2 clear, `cl_fault` does not affect `sync_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for one shadow or control register |
| cfg_wr_sel | input | 3 | 0 period, 1 to 4 events, 5 control |
| cfg_wr_data | input | CNT_W | Write data; control uses bits 2:0 |
| sync_in | input | 1 | Sync pin as seen from the pad (asynchronous) |
| cl_fault | input | 1 | Cycle-by-cycle current-limit fault, synchronous |
| sync_out | output | 1 | Sync pulse driven toward the pad |
| sync_oe | output | 1 | 1 when the pad is driven (leader) |
| pwm_a | output | 1 | Half-bridge output A |
| pwm_b | output | 1 | Half-bridge output B |
| cnt_out | output | CNT_W | Switching counter value |

## Verification
The outputs A, B and `sync_out` are registered, so each one changes one clock after the counter value or fault edge that causes it. A rising edge on the sync input reaches the counter three clocks after the pin changes: two synchronizer stages, then one edge-detect stage. A control write shows on `sync_oe` in the first cycle after the write strobe. The driver starts each test at a cycle where it has seen the counter read 0. It then queues each expected value under the exact absolute cycle that these latencies give. The monitor compares only at the falling clock edge of that cycle.

// File: rtl/dpwm_pkg.sv
// Package: shared constants and types for the half-bridge PWM generator.
// Assumes a register-select field of SEL_W bits; select codes are fixed here.
package dpwm_pkg;

    localparam int SEL_W = 3;
    localparam int NSLOT = 5;       // period + four events

    // Register select codes seen on cfg_wr_sel
    typedef enum logic [SEL_W-1:0] {
        SEL_PRD  = 3'd0,
        SEL_EV1  = 3'd1,
        SEL_EV2  = 3'd2,
        SEL_EV3  = 3'd3,
        SEL_EV4  = 3'd4,
        SEL_CTRL = 3'd5
    } sel_e;

    // Control bits, packed so that bit 0 is the pin direction
    typedef struct packed {
        logic cl_sync_en;     // bit 2: current-limit fault fires a pulse
        logic follow_en;      // bit 1: external restart enabled
        logic pin_is_input;   // bit 0: 1 follower, 0 leader
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{cl_sync_en: 1'b0, follow_en: 1'b0, pin_is_input: 1'b1};

endpackage

// File: rtl/dpwm_regbank.sv
// Register bank: shadow and active copies of the period and event values,
// plus the control bits. Shadow values move to the active set on 'load',
// which the counter raises at every period start. Control bits apply at once.
module dpwm_regbank
    import dpwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DEF_PRD = 99
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [CNT_W-1:0]            wr_data,
    input  logic                        load,
    output logic [NSLOT-1:0][CNT_W-1:0] act,
    output ctrl_t                       ctrl
);

    logic [NSLOT-1:0][CNT_W-1:0] shadow;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [CNT_W-1:0] RST_VAL = (g == 0) ? CNT_W'(DEF_PRD) : '0;
        logic hit;
        assign hit = wr_en && (wr_sel == SEL_W'(g));

        // Capture a software write into the shadow copy
        always_ff @(posedge clk) begin
            if (!rst_n)   shadow[g] <= RST_VAL;
            else if (hit) shadow[g] <= wr_data;
        end

        // Move the shadow copy into the working set at period start
        always_ff @(posedge clk) begin
            if (!rst_n)    act[g] <= RST_VAL;
            else if (load) act[g] <= shadow[g];
        end
    end

    // Update the control bits directly on a control write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= CTRL_RST;
        else if (wr_en && (wr_sel == SEL_CTRL))
            ctrl <= ctrl_t'(wr_data[2:0]);
    end

endmodule

// File: rtl/dpwm_sync_rx.sv
// Sync receiver: brings the asynchronous sync pin into the clock domain
// through STAGES flops and flags one cycle per rising edge.
// Assumes the pin stays at each level for at least two clocks.
module dpwm_sync_rx #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [STAGES:0] chain;

    // Shift the pin level through the synchronizer and history flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/dpwm_counter.sv
// Switching counter: counts 0..prd and wraps; a restart forces zero.
// 'wrap' marks the last count of a period, 'start' marks any period start.
module dpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] prd,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             start
);

    assign wrap  = (cnt >= prd);
    assign start = restart | wrap;

    // Advance, wrap or restart the count
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (start) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/dpwm_chan.sv
// One output channel: goes high the clock after cnt equals set_at and
// low the clock after cnt equals clr_at; the clear wins on a tie.
// Exact-equality compares only: a skipped count leaves the level unchanged.
module dpwm_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] set_at,
    input  logic [CNT_W-1:0] clr_at,
    output logic             q
);

    // Apply the set or clear edge selected by the current count
    always_ff @(posedge clk) begin
        if (!rst_n)              q <= 1'b0;
        else if (cnt == clr_at)  q <= 1'b0;
        else if (cnt == set_at)  q <= 1'b1;
    end

endmodule

// File: rtl/dpwm_sync_tx.sv
// Sync transmitter: in leader mode it sends a one-clock pulse on each
// counter wrap and, if enabled, on a rising current-limit fault.
// Assumes cl_fault is synchronous to clk.
module dpwm_sync_tx (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_is_input,
    input  logic cl_sync_en,
    input  logic cl_fault,
    input  logic wrap,
    output logic sync_out,
    output logic sync_oe
);

    logic fault_q;
    logic fault_rise;

    assign fault_rise = cl_fault & ~fault_q;
    assign sync_oe    = ~pin_is_input;

    // Remember the fault level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= cl_fault;
    end

    // Form the registered sync pulse
    always_ff @(posedge clk) begin
        if (!rst_n) sync_out <= 1'b0;
        else        sync_out <= ~pin_is_input & (wrap | (cl_sync_en & fault_rise));
    end

endmodule

// File: rtl/hb_dpwm.sv
// Top: half-bridge PWM generator with leader/follower synchronization.
// A = events 1/2, B = events 3/4, all relative to a counter that wraps at
// the period value. Dead times are computed by software.
module hb_dpwm
    import dpwm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DEF_PRD     = 99,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [2:0]       cfg_wr_sel,
    input  logic [CNT_W-1:0] cfg_wr_data,
    input  logic             sync_in,
    input  logic             cl_fault,
    output logic             sync_out,
    output logic             sync_oe,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic [CNT_W-1:0] cnt_out
);

    localparam int NCH = 2;

    logic [NSLOT-1:0][CNT_W-1:0] act;
    ctrl_t                       ctrl;
    logic                        load;
    logic                        wrap;
    logic                        rise;
    logic                        restart;
    logic [NCH-1:0]              pwm;
    logic [CNT_W-1:0]            prd_act, ev1_act, ev2_act, ev3_act, ev4_act;

    assign prd_act = act[0];
    assign ev1_act = act[1];
    assign ev2_act = act[2];
    assign ev3_act = act[3];
    assign ev4_act = act[4];

    dpwm_regbank #(.CNT_W(CNT_W), .DEF_PRD(DEF_PRD)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
        .load(load), .act(act), .ctrl(ctrl)
    );

    dpwm_sync_rx #(.STAGES(SYNC_STAGES)) i_rx (
        .clk(clk), .rst_n(rst_n), .pin(sync_in), .rise(rise)
    );

    assign restart = rise & ctrl.follow_en & ctrl.pin_is_input;

    dpwm_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .prd(prd_act), .restart(restart),
        .cnt(cnt_out), .wrap(wrap), .start(load)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dpwm_chan #(.CNT_W(CNT_W)) i_chan (
            .clk(clk), .rst_n(rst_n), .cnt(cnt_out),
            .set_at(act[1 + 2*ch]), .clr_at(act[2 + 2*ch]), .q(pwm[ch])
        );
    end

    assign pwm_a = pwm[0];
    assign pwm_b = pwm[1];

    dpwm_sync_tx i_tx (
        .clk(clk), .rst_n(rst_n),
        .pin_is_input(ctrl.pin_is_input), .cl_sync_en(ctrl.cl_sync_en),
        .cl_fault(cl_fault), .wrap(wrap),
        .sync_out(sync_out), .sync_oe(sync_oe)
    );

endmodule

// File: rtl/hb_dpwm_chk.sv
// Checker: temporal properties of the PWM generator, bound into hb_dpwm.
module hb_dpwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] prd,
    input logic [CNT_W-1:0] ev1,
    input logic [CNT_W-1:0] ev2,
    input logic [CNT_W-1:0] ev4,
    input logic             restart,
    input logic             wrap,
    input logic             is_input,
    input logic             cl_en,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic             sync_out,
    input logic             sync_oe
);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b && cnt == '0 && !sync_out && !sync_oe));

    p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= prd);

    p_a_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == ev1 && cnt != ev2) |=> pwm_a);

    p_b_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == ev4) |=> !pwm_b);

    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    p_follower_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_input |=> !sync_out);

    p_fault_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cl_en && !wrap) |=> !sync_out);

endmodule

bind hb_dpwm hb_dpwm_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_out), .prd(prd_act),
    .ev1(ev1_act), .ev2(ev2_act), .ev4(ev4_act),
    .restart(restart), .wrap(wrap),
    .is_input(ctrl.pin_is_input), .cl_en(ctrl.cl_sync_en),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .sync_out(sync_out), .sync_oe(sync_oe)
);

// File: tb/test_hb_dpwm.sv
// Scoreboard bench: driver tasks queue expected values per absolute cycle,
// a monitor compares them at the falling edge of that cycle.
module test_hb_dpwm;

    localparam int CNT_W = 16;
    localparam int SIG_CNT = 0, SIG_A = 1, SIG_B = 2, SIG_SO = 3, SIG_OE = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [2:0]       cfg_wr_sel = '0;
    logic [CNT_W-1:0] cfg_wr_data = '0;
    logic             sync_in = 1'b0;
    logic             cl_fault = 1'b0;
    logic             sync_out, sync_oe, pwm_a, pwm_b;
    logic [CNT_W-1:0] cnt_out;

    hb_dpwm #(.CNT_W(CNT_W)) i_hb_dpwm (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .sync_in(sync_in), .cl_fault(cl_fault),
        .sync_out(sync_out), .sync_oe(sync_oe), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .cnt_out(cnt_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        int    cyc;
        int    sig;
        int    val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    int   act_v;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sig_val(int s);
        case (s)
            SIG_CNT: return int'(cnt_out);
            SIG_A:   return int'(pwm_a);
            SIG_B:   return int'(pwm_b);
            SIG_SO:  return int'(sync_out);
            default: return int'(sync_oe);
        endcase
    endfunction

    // Monitor: pop and compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].cyc == cyc) begin
                act_v = sig_val(exp_q[i].sig);
                n_cmp++;
                if (act_v != exp_q[i].val) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d signal %0d: actual %0d expected %0d",
                             exp_q[i].req, cyc, exp_q[i].sig, act_v, exp_q[i].val);
                end
                exp_q.delete(i);
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_at(int abs_cyc, int s, int v, string req);
        exp_t e;
        e.cyc = abs_cyc; e.sig = s; e.val = v; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wr(int sel, int data);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = 3'(sel);
        cfg_wr_data = CNT_W'(data);
        step(1);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic wait_zero();
        do step(1); while (cnt_out != '0);
    endtask

    localparam int PRD = 19, EV1 = 2, DT1 = 2, DT2 = 1;
    int ev3, ev2, m;

    initial begin
        ev3 = (PRD + EV1) >> 1;
        ev2 = ev3 - DT1;

        // R1: state held in reset
        step(3);
        expect_at(cyc, SIG_A, 0, "R1");
        expect_at(cyc, SIG_B, 0, "R1");
        expect_at(cyc, SIG_CNT, 0, "R1");
        expect_at(cyc, SIG_SO, 0, "R1");
        expect_at(cyc, SIG_OE, 0, "R1");
        rst_n = 1'b1;
        // R2: counting under the default period
        expect_at(cyc + 1, SIG_CNT, 1, "R2");
        expect_at(cyc + 5, SIG_CNT, 5, "R2");

        // R3 / R4: half-bridge pattern
        wr(0, PRD); wr(1, EV1); wr(2, ev2); wr(3, ev3); wr(4, EV1 - DT2);
        wait_zero();
        m = cyc;
        expect_at(m + EV1, SIG_A, 0, "R3");
        expect_at(m + EV1 + 1, SIG_A, 1, "R3");
        expect_at(m + ev2, SIG_A, 1, "R3");
        expect_at(m + ev2 + 1, SIG_A, 0, "R3");
        expect_at(m + ev3, SIG_B, 0, "R4");
        expect_at(m + ev3 + 1, SIG_B, 1, "R4");
        expect_at(m + PRD + 1 + 1, SIG_B, 1, "R4");
        expect_at(m + PRD + 1 + 2, SIG_B, 0, "R4");
        expect_at(m + PRD, SIG_CNT, PRD, "R2");
        expect_at(m + PRD + 1, SIG_CNT, 0, "R2");
        step(23);

        // R8: leader sends one pulse per wrap
        wr(5, 0);
        expect_at(cyc, SIG_OE, 1, "R8");
        wait_zero();
        m = cyc;
        expect_at(m, SIG_SO, 1, "R8");
        expect_at(m + 1, SIG_SO, 0, "R8");
        expect_at(m + PRD, SIG_SO, 0, "R8");
        expect_at(m + PRD + 1, SIG_SO, 1, "R8");
        expect_at(m + PRD + 2, SIG_SO, 0, "R8");
        step(22);

        // R9: fault pulse enabled
        wr(5, 4);
        wait_zero();
        step(1);
        cl_fault = 1'b1;
        expect_at(cyc + 1, SIG_SO, 1, "R9");
        expect_at(cyc + 2, SIG_SO, 0, "R9");
        expect_at(cyc + PRD, SIG_SO, 1, "R9");
        step(4);
        cl_fault = 1'b0;
        step(18);

        // R9: fault pulse disabled, wrap pulse still present
        wr(5, 0);
        wait_zero();
        step(1);
        cl_fault = 1'b1;
        expect_at(cyc + 1, SIG_SO, 0, "R9");
        expect_at(cyc + 2, SIG_SO, 0, "R9");
        expect_at(cyc + PRD, SIG_SO, 1, "R9");
        step(4);
        cl_fault = 1'b0;
        step(18);

        // R6: follower restart on a rising edge, three clocks later
        wr(5, 3);
        expect_at(cyc, SIG_OE, 0, "R8");
        wait_zero();
        step(5);
        sync_in = 1'b1;
        expect_at(cyc + 2, SIG_CNT, 7, "R6");
        expect_at(cyc + 3, SIG_CNT, 0, "R6");
        expect_at(cyc + 4, SIG_CNT, 1, "R6");
        expect_at(cyc + 3, SIG_SO, 0, "R8");
        step(7);
        sync_in = 1'b0;                       // falling edge: no restart
        expect_at(cyc + 3, SIG_CNT, 7, "R6");
        expect_at(cyc + 4, SIG_CNT, 8, "R6");
        step(6);

        // R6: following disabled
        wr(5, 1);
        wait_zero();
        step(5);
        sync_in = 1'b1;
        expect_at(cyc + 3, SIG_CNT, 8, "R6");
        expect_at(cyc + 4, SIG_CNT, 9, "R6");
        step(5);
        sync_in = 1'b0;
        step(3);

        // R7: restart before event 4 stretches B
        wr(5, 3);
        wr(4, 16);
        wait_zero();
        step(ev3);
        sync_in = 1'b1;
        expect_at(cyc + 1, SIG_B, 1, "R7");
        expect_at(cyc + 3, SIG_CNT, 0, "R7");
        expect_at(cyc + 7, SIG_B, 1, "R7");
        expect_at(cyc + 19, SIG_B, 1, "R7");
        expect_at(cyc + 20, SIG_B, 0, "R7");
        step(6);
        sync_in = 1'b0;
        step(14);

        // R7: event 4 at zero ends B on the restart
        wr(4, 0);
        wait_zero();
        expect_at(cyc + 1, SIG_B, 0, "R7");
        step(ev3);
        sync_in = 1'b1;
        expect_at(cyc + 1, SIG_B, 1, "R7");
        expect_at(cyc + 3, SIG_B, 1, "R7");
        expect_at(cyc + 3, SIG_CNT, 0, "R7");
        expect_at(cyc + 4, SIG_B, 0, "R7");
        step(6);
        sync_in = 1'b0;
        step(10);

        // R5: period write applies from the next period only
        wait_zero();
        m = cyc;
        step(2);
        wr(0, 9);
        expect_at(m + PRD, SIG_CNT, PRD, "R5");
        expect_at(m + PRD + 1, SIG_CNT, 0, "R5");
        expect_at(m + PRD + 10, SIG_CNT, 9, "R5");
        expect_at(m + PRD + 11, SIG_CNT, 0, "R5");
        step(32);

        step(2);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL all: %0d expected items never compared (expected 0)", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL all: watchdog expired at cycle %0d (expected completion)", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule